// File: doc/BRIEF.md
# Saturating Sample Splitter with Range Flag

This block sits after a converter core that hands over one signed sample on every clock. Each sample is wider than the output code. The block limits it to the 8-bit range and sets a per-sample range flag whenever limiting took place. It then re-codes the value as offset binary, so the most negative code is all zeros and the most positive is all ones.

The conditioned stream is dealt onto two half-rate output buses. Samples alternate between them: even-indexed samples go to the delayed bus and odd-indexed samples go to the primary bus. Both buses load on the same clock edge, so a consumer always sees a matching pair, older sample on the delayed bus and newer one on the primary bus. A toggle strobe changes on each pair load. A downstream unit rebuilds the full-rate stream by reading the delayed word first and the primary word second. The fixed delay is 13 clocks for the primary bus and 14 clocks for the delayed bus. A synchronous reset empties the pipeline and restarts the sample indexing at zero.

Top module: `smpdemux`

## Requirements
- R1: An input value v with -128 <= v <= 127 yields code v+128 (offset binary, for example 0 gives 0x80 and -1 gives 0x7F), with the range flag low.
- R2: An input value below -128 yields code 0x00 with the range flag high.
- R3: An input value above 127 yields code 0xFF with the range flag high.
- R4: The boundary values -128 and 127 yield 0x00 and 0xFF with the range flag low.
- R5: The sample taken at edge n, with n odd, is shown on p_word and p_oor after edge n+13.
- R6: The sample taken at edge n, with n even, is shown on d_word and d_oor after edge n+14.
- R7: Both buses change only at the pair-load edges, which are 2 clocks apart, and hold their values between them.
- R8: pair_rdy starts at 0 and inverts at each pair load, and only then. The first load is at edge 14 after reset is released.
- R9: While rst is high at a clock edge, all outputs go to zero, the pipeline empties and the sample index restarts. The first edge with rst low takes sample 0, which is even. Until the first pair load the outputs stay at zero.
- R10: Each bus carries its own range flag, taken from the same sample as its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | IN_W (12) | Two's-complement sample, one taken per clock |
| p_word | output | OUT_W (8) | Primary bus code (odd-indexed samples) |
| p_oor | output | 1 | Range flag for p_word |
| d_word | output | OUT_W (8) | Delayed bus code (even-indexed samples) |
| d_oor | output | 1 | Range flag for d_word |
| pair_rdy | output | 1 | Toggles at each pair load |

## Verification
A wrong phase bit inside the pipeline would swap the two buses, or shift the load edge by one clock. That error shows up at the very first pair load, 14 clocks after reset: the words would be one sample off, and pair_rdy would toggle on the wrong edge. A corrupted limiting decision shows as a code that does not match the flag, 13 or 14 clocks after the offending sample. The bench therefore places the limits and their neighbours on both even and odd indices. It also resets in the middle of a run at an odd phase and checks every port on every clock.

// File: rtl/smpdemux_pkg.sv
package smpdemux_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Outcome of the range test on one sample
  typedef enum logic [1:0] {
    RANGE_IN   = 2'd0,
    RANGE_LOW  = 2'd1,
    RANGE_HIGH = 2'd2
  } range_e;

  // Bit offsets of the control fields above the code inside a pipeline entry
  localparam int ENTRY_CTL_BITS = 3;
endpackage

// File: rtl/smpdemux_sat.sv
module smpdemux_sat
  import smpdemux_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input  logic signed [IN_W-1:0] smp,
  output logic [OUT_W-1:0]       code,
  output logic                   oor
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HI_I = (2 ** (OUT_W - 1)) - 1;
  localparam int LO_I = -(2 ** (OUT_W - 1));
  localparam logic signed [IN_W-1:0] HI = IN_W'(HI_I);
  localparam logic signed [IN_W-1:0] LO = IN_W'(LO_I);

  range_e rng;

  always_comb begin
    if (smp > HI)      rng = RANGE_HIGH;
    else if (smp < LO) rng = RANGE_LOW;
    else               rng = RANGE_IN;
  end

  // Offset binary: the sign bit of the in-range value is inverted
  always_comb begin
    case (rng)
      RANGE_HIGH: code = '1;
      RANGE_LOW:  code = '0;
      default:    code = {~smp[OUT_W-1], smp[OUT_W-2:0]};
    endcase
  end

  assign oor = (rng != RANGE_IN);
endmodule

// File: rtl/smpdemux_dly.sv
module smpdemux_dly #(
  parameter int W     = 11,
  parameter int DEPTH = 14,
  parameter int TAP_A = 12,
  parameter int TAP_B = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic [W-1:0] tap_a,
  output logic [W-1:0] tap_b
);
  timeunit 1ns;
  timeprecision 100ps;

  // Flip-flop chain rather than a RAM: every stage must clear on reset
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '{default: '0};
    end else begin
      stg[0] <= din;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  generate
    if (TAP_A < DEPTH && TAP_B < DEPTH) begin : g_taps
      assign tap_a = stg[TAP_A];
      assign tap_b = stg[TAP_B];
    end else begin : g_taps_clip
      assign tap_a = stg[DEPTH-1];
      assign tap_b = stg[DEPTH-1];
    end
  endgenerate

  assign head = stg[0];
endmodule

// File: rtl/smpdemux_out.sv
module smpdemux_out #(
  parameter int OUT_W = 8,
  parameter int W     = OUT_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     ent_p,
  input  logic [W-1:0]     ent_d,
  output logic [OUT_W-1:0] p_word,
  output logic             p_oor,
  output logic [OUT_W-1:0] d_word,
  output logic             d_oor,
  output logic             pair_rdy
);
  timeunit 1ns;
  timeprecision 100ps;

  // Entry layout: {valid, odd, oor, code}
  localparam int VLD = W - 1;
  localparam int ODD = W - 2;
  localparam int OOR = W - 3;

  logic load;

  // Load when an odd sample reaches the primary tap with its even partner behind it
  assign load = ent_p[VLD] & ent_p[ODD] & ent_d[VLD] & ~ent_d[ODD];

  always_ff @(posedge clk) begin
    if (rst) begin
      p_word   <= '0;
      p_oor    <= 1'b0;
      d_word   <= '0;
      d_oor    <= 1'b0;
      pair_rdy <= 1'b0;
    end else if (load) begin
      p_word   <= ent_p[OUT_W-1:0];
      p_oor    <= ent_p[OOR];
      d_word   <= ent_d[OUT_W-1:0];
      d_oor    <= ent_d[OOR];
      pair_rdy <= ~pair_rdy;
    end
  end
endmodule

// File: rtl/smpdemux.sv
module smpdemux
  import smpdemux_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8,
  parameter int LAT_P = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  smp_in,
  output logic [OUT_W-1:0] p_word,
  output logic             p_oor,
  output logic [OUT_W-1:0] d_word,
  output logic             d_oor,
  output logic             pair_rdy
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int LAT_D = LAT_P + 1;
  localparam int EW    = OUT_W + ENTRY_CTL_BITS;
  localparam int DEPTH = LAT_D;

  logic [OUT_W-1:0] code_c;
  logic             oor_c;
  logic             phase;
  logic [EW-1:0]    entry_c;
  logic [EW-1:0]    head_q;
  logic [EW-1:0]    tap_p;
  logic [EW-1:0]    tap_d;

  smpdemux_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat (
    .smp  ($signed(smp_in)),
    .code (code_c),
    .oor  (oor_c)
  );

  // Sample index parity; index 0 is the first sample after reset
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  assign entry_c = {1'b1, phase, oor_c, code_c};

  // A sample taken at edge n sits in stage k after edge n+k
  smpdemux_dly #(
    .W(EW), .DEPTH(DEPTH), .TAP_A(LAT_P - 1), .TAP_B(LAT_D - 1)
  ) u_dly (
    .clk   (clk),
    .rst   (rst),
    .din   (entry_c),
    .head  (head_q),
    .tap_a (tap_p),
    .tap_b (tap_d)
  );

  smpdemux_out #(.OUT_W(OUT_W), .W(EW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .ent_p    (tap_p),
    .ent_d    (tap_d),
    .p_word   (p_word),
    .p_oor    (p_oor),
    .d_word   (d_word),
    .d_oor    (d_oor),
    .pair_rdy (pair_rdy)
  );
endmodule

// File: rtl/smpdemux_chk.sv
module smpdemux_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [IN_W-1:0]  smp_in,
  input logic [OUT_W+2:0] head_q,
  input logic [OUT_W-1:0] p_word,
  input logic             p_oor,
  input logic [OUT_W-1:0] d_word,
  input logic             d_oor,
  input logic             pair_rdy
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int HALF = 2 ** (OUT_W - 1);
  localparam logic signed [IN_W-1:0] HI = IN_W'(HALF - 1);
  localparam logic signed [IN_W-1:0] LO = IN_W'(-HALF);
  localparam int OOR = OUT_W;
  localparam int VLD = OUT_W + 2;

  logic signed [IN_W-1:0] sv;
  assign sv = $signed(smp_in);

  // R1 in-range values are offset by half the code span
  a_r1_offset_code: assert property (@(posedge clk) disable iff (rst)
    (sv >= LO && sv <= HI) |=>
      (head_q[OUT_W-1:0] == OUT_W'(int'($past(sv)) + HALF)) && !head_q[OOR]);

  // R2 under-range clamps to zero code with flag
  a_r2_under_clamp: assert property (@(posedge clk) disable iff (rst)
    (sv < LO) |=> (head_q[OUT_W-1:0] == '0) && head_q[OOR]);

  // R3 over-range clamps to all-ones code with flag
  a_r3_over_clamp: assert property (@(posedge clk) disable iff (rst)
    (sv > HI) |=> (head_q[OUT_W-1:0] == '1) && head_q[OOR]);

  // R4 limits themselves are not flagged
  a_r4_limit_unflagged: assert property (@(posedge clk) disable iff (rst)
    (sv == LO || sv == HI) |=> !head_q[OOR]);

  // R7 buses hold unless a pair load happens
  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    $stable(pair_rdy) |-> ($stable(p_word) && $stable(d_word) &&
                           $stable(p_oor) && $stable(d_oor)));

  // R8 no two loads on adjacent edges
  a_r8_half_rate: assert property (@(posedge clk) disable iff (rst)
    !$stable(pair_rdy) |=> $stable(pair_rdy));

  // R9 reset empties outputs and pipeline head
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (pair_rdy == 1'b0 && p_word == '0 && d_word == '0 &&
             !p_oor && !d_oor && !head_q[VLD]));

  // R10 a raised flag goes with a limit code on each bus
  a_r10_flag_primary: assert property (@(posedge clk) disable iff (rst)
    p_oor |-> (p_word == '0 || p_word == '1));
  a_r10_flag_delayed: assert property (@(posedge clk) disable iff (rst)
    d_oor |-> (d_word == '0 || d_word == '1));
endmodule

bind smpdemux smpdemux_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_in   (smp_in),
  .head_q   (head_q),
  .p_word   (p_word),
  .p_oor    (p_oor),
  .d_word   (d_word),
  .d_oor    (d_oor),
  .pair_rdy (pair_rdy)
);

// File: tb/smpdemux_test.sv
module smpdemux_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IN_W = 12;
  localparam int OUT_W = 8;
  localparam int LP = 13;
  localparam int LD = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0] smp_in = '0;
  logic [OUT_W-1:0] p_word, d_word;
  logic p_oor, d_oor, pair_rdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int samp [512];

  always #2.5 clk = ~clk;

  smpdemux uut (
    .clk(clk), .rst(rst), .smp_in(smp_in),
    .p_word(p_word), .p_oor(p_oor), .d_word(d_word), .d_oor(d_oor),
    .pair_rdy(pair_rdy)
  );

  function automatic void ref_enc(input int v, output int code, output int oor,
                                  output string tag);
    if (v < -128)      begin code = 0;       oor = 1; tag = "R2"; end
    else if (v > 127)  begin code = 255;     oor = 1; tag = "R3"; end
    else begin
      code = v + 128; oor = 0;
      tag = (v == -128 || v == 127) ? "R4" : "R1";
    end
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_zero(input string req);
    chk(p_word == 0, req, p_word, 0);
    chk(d_word == 0, req, d_word, 0);
    chk(p_oor == 0, req, p_oor, 0);
    chk(d_oor == 0, req, d_oor, 0);
    chk(pair_rdy == 0, req, pair_rdy, 0);
  endtask

  // Outputs after edge e (edges counted from reset release)
  task automatic check_edge(input int e);
    int u, pc, po, dc, dov, rdy;
    string pt, dt, hold;
    if (e < LD) begin
      check_zero("R9 before first load");
      return;
    end
    u = e - (e % 2);
    ref_enc(samp[u - LP], pc, po, pt);
    ref_enc(samp[u - LD], dc, dov, dt);
    rdy = (((u - LD) / 2) + 1) % 2;
    hold = (e % 2) ? " R7 hold" : "";
    chk(p_word == pc, $sformatf("R5 %s%s primary word e=%0d", pt, hold, e), p_word, pc);
    chk(p_oor == po, $sformatf("R10 R5 primary flag e=%0d", e), p_oor, po);
    chk(d_word == dc, $sformatf("R6 %s%s delayed word e=%0d", dt, hold, e), d_word, dc);
    chk(d_oor == dov, $sformatf("R10 R6 delayed flag e=%0d", e), d_oor, dov);
    chk(pair_rdy == rdy, $sformatf("R8 strobe e=%0d", e), pair_rdy, rdy);
  endtask

  // Caller releases rst on a falling edge; drives sample e ahead of edge e
  task automatic run_seq(input int edges);
    for (int e = 0; e < edges; e++) begin
      smp_in = IN_W'(samp[e]);
      @(negedge clk);
      check_edge(e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int dir [24];
    dir = '{-2048, -129, -128, -127, -1, 0, 1, 126, 127, 128, 2047, 300,
            -300, 127, -128, 128, -129, 64, -64, 5, 2047, -2048, 0, 1};
    foreach (samp[i]) samp[i] = 0;
    foreach (dir[i]) samp[i] = dir[i];
    for (int i = 24; i < 60; i++) samp[i] = -200 + (i - 24) * 13;

    repeat (4) @(negedge clk);
    check_zero("R9 reset state");
    rst = 1'b0;
    run_seq(77);              // ends with an odd phase pending

    // R9: mid-run reset clears outputs and restarts sample index at 0
    rst = 1'b1;
    @(negedge clk);
    check_zero("R9 mid-run reset");
    @(negedge clk);
    check_zero("R9 reset held");

    foreach (samp[i]) samp[i] = 0;
    for (int i = 0; i < 120; i++) samp[i] = int'($urandom_range(0, 1023)) - 512;
    samp[7] = -128; samp[8] = 127; samp[9] = -129; samp[10] = 128;
    rst = 1'b0;
    run_seq(136);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule